// File: doc/BRIEF.md
# Asynchronous Static Memory Bus Controller

This block sits between an internal requester and an external bus that is shared by four asynchronous static devices (SRAM, PSRAM or NOR). It accepts one read or write request at a time and plays it out on the shared address, data and strobe pins. Each device has its own chip select. Every part of the external cycle is a count of controller clocks taken from that bank's configuration word. The parts are byte-lane lead-in, address setup, optional address hold, data setup, data hold and turnaround. Writes may use timings that differ from reads.

The request side is a valid/ready port. The requester raises `req_valid` with its payload and must keep both stable until it sees `req_ready` high. `req_ready` is a single-clock pulse that marks the end of the external cycle. The transfer happens in that clock, and a new request may be presented in the very next clock. The controller applies back-pressure for the whole external cycle and for the turnaround that follows it. For a read, `rsp_rdata` is valid in the clock where `req_ready` is high, and it holds that value until the next read is captured.

A bank may multiplex its low address bits onto the data pins, or be set to 8-bit width. It may also honour a wait input of either polarity that stretches data setup. The configuration words are plain inputs and are expected to be static while a bank is in use.

Top module: `sbc_top`

## Requirements
- R1: At most one chip select is low at any time, and it is the one selected by `req_bank`. After reset, and while no access runs, every chip select and byte lane is high, both strobes are high, `mem_addr` is zero and `mem_dq_oe` is low.
- R2: Bank b's configuration is `cfg_banks[b*49 +: 49]`. An access runs through these parts in order:
  - byte lanes low with chip select still high, for max(bits 43:40, 1) clocks;
  - chip select low for address setup, for max(AS, 1) clocks;
  - data setup, for max(DS, 1) clocks, with `mem_oe_n` low on reads or `mem_we_n` low on writes;
  - data hold, for DH clocks (zero allowed), with chip select still low and both strobes high.
- R3: Reads take their timings from bits 3:0 (AS), 7:4 (AH), 11:8 (DS), 15:12 (DH) and 19:16 (TA). Writes take theirs from bits 23:20, 27:24, 31:28, 35:32 and 39:36, in the same order.
- R4: When bit 47 (multiplex) is set and bit 48 (SRAM-type bank) is clear, an address hold of AH clocks follows address setup. The data pins then carry `req_addr[DW-1:0]` through address setup and hold. When bit 48 is set, bit 47 has no effect.
- R5: After an access ends, the next access's byte-lane part begins no sooner than max(TA, 1)+1 clocks after the `req_ready` clock.
- R6: `req_ready` is high for exactly one clock: the clock after the last data-hold clock, or after the last data-setup clock when DH is zero.
- R7: Read data is sampled from `mem_dq_i` on the last data-setup clock and presented on `rsp_rdata` while `req_ready` is high.
- R8: During a write, the data pins carry write data from the first data-setup clock to the last data-hold clock. During a read, the data pins are never driven.
- R9: With bit 46 clear (default), the bank is 16 bits wide and the byte lanes follow `~req_be`. With bit 46 set, only lane 0 is enabled, write data is the low byte zero-extended, and read data is the low byte zero-extended.
- R10: With bit 45 set, the wait input is active when `mem_wait` equals bit 44 (0 = active low). While it is active, data setup continues past its count and ends on the first clock that both reaches the count and sees wait inactive. With bit 45 clear, `mem_wait` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | One-clock completion / transfer pulse |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BW | Target bank (chip select index) |
| req_addr | input | AW | Device address |
| req_wdata | input | DW | Write data |
| req_be | input | NBE | Byte enables, active high |
| rsp_rdata | output | DW | Captured read data |
| cfg_banks | input | NBANK*49 | Per-bank timing and mode words |
| mem_addr | output | AW | External address |
| mem_dq_o | output | DW | External data, outgoing half |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_o` |
| mem_dq_i | input | DW | External data, incoming half |
| mem_cs_n | output | NBANK | Chip selects, active low |
| mem_ble_n | output | NBE | Byte-lane enables, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_wait | input | 1 | Device wait, polarity per bank |

## Verification
The assertions assume the requester keeps `req_valid` and its payload stable until the `req_ready` pulse. They also assume that the configuration word of a bank does not change while that bank's access or turnaround runs, and that `mem_wait` is already synchronous to `clk`. The stimulus meets these assumptions by construction. It changes requests only on the falling edge, and only right after a ready pulse or while idle. It rewrites configuration words only after several idle clocks. It drives `mem_wait` and `mem_dq_i` from the same per-clock expectation queue that predicts the pins, so wait is asserted only in chosen data-setup clocks, and the bus carries the correct read value only on the clock where capture should occur.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  localparam int TW = 4;

  // one bank's configuration word, MSB first
  typedef struct packed {
    logic          sram_type;
    logic          mux_en;
    logic          narrow;
    logic          wait_en;
    logic          wait_hi;
    logic [TW-1:0] bl_setup;
    logic [TW-1:0] w_turn;
    logic [TW-1:0] w_dhold;
    logic [TW-1:0] w_dsetup;
    logic [TW-1:0] w_ahold;
    logic [TW-1:0] w_asetup;
    logic [TW-1:0] r_turn;
    logic [TW-1:0] r_dhold;
    logic [TW-1:0] r_dsetup;
    logic [TW-1:0] r_ahold;
    logic [TW-1:0] r_asetup;
  } bank_cfg_t;

  localparam int CFG_W = $bits(bank_cfg_t);

  // resolved timing for the access in flight
  typedef struct packed {
    logic [TW-1:0] bls;
    logic [TW-1:0] asu;
    logic [TW-1:0] ahd;
    logic [TW-1:0] dsu;
    logic [TW-1:0] dhd;
    logic [TW-1:0] trn;
    logic          mux;
    logic          narrow;
  } timing_t;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_BLS  = 3'd1,
    PH_ASU  = 3'd2,
    PH_AHD  = 3'd3,
    PH_DSU  = 3'd4,
    PH_DHD  = 3'd5,
    PH_TRN  = 3'd6
  } phase_e;

endpackage

// File: rtl/sbc_cfg_sel.sv
module sbc_cfg_sel
  import sbc_pkg::*;
#(
  parameter  int NBANK = 4,
  localparam int BW    = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic [NBANK*CFG_W-1:0] cfg_flat,
  input  logic [BW-1:0]          bank,
  input  logic                   write,
  input  logic                   mem_wait,
  output timing_t                tim,
  output logic                   wait_act
);

  bank_cfg_t cfgs [NBANK];
  bank_cfg_t c;

  for (genvar g = 0; g < NBANK; g++) begin : g_unpack
    assign cfgs[g] = cfg_flat[g*CFG_W +: CFG_W];
  end

  assign c = cfgs[bank];

  function automatic logic [TW-1:0] at_least1(input logic [TW-1:0] v);
    return (v == '0) ? TW'(1) : v;
  endfunction

  always_comb begin
    tim.bls    = at_least1(c.bl_setup);
    tim.asu    = at_least1(write ? c.w_asetup : c.r_asetup);
    tim.ahd    = write ? c.w_ahold : c.r_ahold;
    tim.dsu    = at_least1(write ? c.w_dsetup : c.r_dsetup);
    tim.dhd    = write ? c.w_dhold : c.r_dhold;
    tim.trn    = write ? c.w_turn  : c.r_turn;
    tim.mux    = c.mux_en & ~c.sram_type;
    tim.narrow = c.narrow;
  end

  assign wait_act = c.wait_en & (mem_wait == c.wait_hi);

endmodule

// File: rtl/sbc_seq.sv
module sbc_seq
  import sbc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  timing_t tim,
  input  logic    wait_act,
  output phase_e  phase,
  output logic    ack,
  output logic    cap
);

  logic [TW-1:0] cnt;
  logic          data_end;

  assign cap      = (phase == PH_DSU) && (cnt == '0) && !wait_act;
  assign data_end = (cap && (tim.dhd == '0)) ||
                    ((phase == PH_DHD) && (cnt == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      ack   <= 1'b0;
    end else begin
      ack <= 1'b0;
      if (data_end) begin
        ack <= 1'b1;
        if (tim.trn != '0) begin
          phase <= PH_TRN;
          cnt   <= tim.trn - 1'b1;
        end else begin
          phase <= PH_IDLE;
        end
      end else begin
        unique case (phase)
          PH_IDLE: if (start) begin
            phase <= PH_BLS;
            cnt   <= tim.bls - 1'b1;
          end
          PH_BLS: begin
            if (cnt == '0) begin
              phase <= PH_ASU;
              cnt   <= tim.asu - 1'b1;
            end else cnt <= cnt - 1'b1;
          end
          PH_ASU: begin
            if (cnt != '0) cnt <= cnt - 1'b1;
            else if (tim.mux && (tim.ahd != '0)) begin
              phase <= PH_AHD;
              cnt   <= tim.ahd - 1'b1;
            end else begin
              phase <= PH_DSU;
              cnt   <= tim.dsu - 1'b1;
            end
          end
          PH_AHD: begin
            if (cnt == '0) begin
              phase <= PH_DSU;
              cnt   <= tim.dsu - 1'b1;
            end else cnt <= cnt - 1'b1;
          end
          PH_DSU: begin
            if (cap) begin
              phase <= PH_DHD;
              cnt   <= tim.dhd - 1'b1;
            end else if (cnt != '0) cnt <= cnt - 1'b1;
          end
          PH_DHD: cnt <= cnt - 1'b1;
          PH_TRN: begin
            if (cnt == '0) phase <= PH_IDLE;
            else cnt <= cnt - 1'b1;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/sbc_pins.sv
module sbc_pins
  import sbc_pkg::*;
#(
  parameter  int NBANK = 4,
  parameter  int AW    = 24,
  parameter  int DW    = 16,
  localparam int BW    = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int NBE   = DW / 8
) (
  input  phase_e           phase,
  input  timing_t          tim,
  input  logic [BW-1:0]    bank,
  input  logic             write,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [NBE-1:0]   be,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_dq_o,
  output logic             mem_dq_oe,
  output logic [NBANK-1:0] mem_cs_n,
  output logic [NBE-1:0]   mem_ble_n,
  output logic             mem_oe_n,
  output logic             mem_we_n
);

  logic lanes_on, sel_on, addr_ph, data_ph;

  assign lanes_on = (phase == PH_BLS) || sel_on;
  assign sel_on   = addr_ph || data_ph;
  assign addr_ph  = (phase == PH_ASU) || (phase == PH_AHD);
  assign data_ph  = (phase == PH_DSU) || (phase == PH_DHD);

  for (genvar g = 0; g < NBANK; g++) begin : g_cs
    assign mem_cs_n[g] = !(sel_on && (bank == BW'(g)));
  end

  always_comb begin
    if (!lanes_on)       mem_ble_n = '1;
    else if (tim.narrow) mem_ble_n = {{(NBE-1){1'b1}}, 1'b0};
    else                 mem_ble_n = ~be;
  end

  assign mem_addr = lanes_on ? addr : '0;
  assign mem_oe_n = !((phase == PH_DSU) && !write);
  assign mem_we_n = !((phase == PH_DSU) && write);

  always_comb begin
    mem_dq_oe = 1'b0;
    mem_dq_o  = '0;
    if (addr_ph && tim.mux) begin
      mem_dq_oe = 1'b1;
      mem_dq_o  = addr[DW-1:0];
    end else if (data_ph && write) begin
      mem_dq_oe = 1'b1;
      mem_dq_o  = tim.narrow ? {{(DW-8){1'b0}}, wdata[7:0]} : wdata;
    end
  end

endmodule

// File: rtl/sbc_top.sv
module sbc_top
  import sbc_pkg::*;
#(
  parameter  int NBANK = 4,
  parameter  int AW    = 24,
  parameter  int DW    = 16,
  localparam int BW    = (NBANK > 1) ? $clog2(NBANK) : 1,
  localparam int NBE   = DW / 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [BW-1:0]          req_bank,
  input  logic [AW-1:0]          req_addr,
  input  logic [DW-1:0]          req_wdata,
  input  logic [NBE-1:0]         req_be,
  output logic [DW-1:0]          rsp_rdata,
  input  logic [NBANK*CFG_W-1:0] cfg_banks,
  output logic [AW-1:0]          mem_addr,
  output logic [DW-1:0]          mem_dq_o,
  output logic                   mem_dq_oe,
  input  logic [DW-1:0]          mem_dq_i,
  output logic [NBANK-1:0]       mem_cs_n,
  output logic [NBE-1:0]         mem_ble_n,
  output logic                   mem_oe_n,
  output logic                   mem_we_n,
  input  logic                   mem_wait
);

  phase_e         phase;
  timing_t        tim;
  logic           wait_act, ack, cap, start;
  logic [BW-1:0]  lat_bank, sel_bank;
  logic           lat_write, sel_write;
  logic [AW-1:0]  lat_addr;
  logic [DW-1:0]  lat_wdata;
  logic [NBE-1:0] lat_be;

  assign start     = req_valid && !ack && (phase == PH_IDLE);
  assign sel_bank  = (phase == PH_IDLE) ? req_bank  : lat_bank;
  assign sel_write = (phase == PH_IDLE) ? req_write : lat_write;
  assign req_ready = ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_bank  <= '0;
      lat_write <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      lat_be    <= '0;
    end else if (start) begin
      lat_bank  <= req_bank;
      lat_write <= req_write;
      lat_addr  <= req_addr;
      lat_wdata <= req_wdata;
      lat_be    <= req_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_rdata <= '0;
    else if (cap && !lat_write)
      rsp_rdata <= tim.narrow ? {{(DW-8){1'b0}}, mem_dq_i[7:0]} : mem_dq_i;
  end

  sbc_cfg_sel #(.NBANK(NBANK)) u_cfg (
    .cfg_flat (cfg_banks),
    .bank     (sel_bank),
    .write    (sel_write),
    .mem_wait (mem_wait),
    .tim      (tim),
    .wait_act (wait_act)
  );

  sbc_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .tim      (tim),
    .wait_act (wait_act),
    .phase    (phase),
    .ack      (ack),
    .cap      (cap)
  );

  sbc_pins #(.NBANK(NBANK), .AW(AW), .DW(DW)) u_pins (
    .phase     (phase),
    .tim       (tim),
    .bank      (lat_bank),
    .write     (lat_write),
    .addr      (lat_addr),
    .wdata     (lat_wdata),
    .be        (lat_be),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe),
    .mem_cs_n  (mem_cs_n),
    .mem_ble_n (mem_ble_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n)
  );

endmodule

// File: rtl/sbc_chk.sv
module sbc_chk
  import sbc_pkg::*;
#(
  parameter int NBANK = 4,
  parameter int NBE   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NBANK-1:0] cs_n,
  input logic [NBE-1:0]   ble_n,
  input logic             oe_n,
  input logic             we_n,
  input logic             dq_oe,
  input logic             ready,
  input phase_e           phase,
  input logic             wait_act
);

  // R1: never two devices selected
  a_r1_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  // R2: a selected device always has its byte lanes enabled
  a_r2_lanes_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != '1) |-> (ble_n != '1));

  // R2: read and write strobes never overlap
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  // R8: no contention while the device drives the bus
  a_r8_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe);

  // R6: completion is a single-clock pulse
  a_r6_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  // R6: completion follows a data phase
  a_r6_ready_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(phase) == PH_DSU || $past(phase) == PH_DHD));

  // R10: an active wait keeps data setup open
  a_r10_wait_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DSU && wait_act) |=> (phase == PH_DSU));

endmodule

bind sbc_top sbc_chk #(.NBANK(NBANK), .NBE(NBE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_n     (mem_cs_n),
  .ble_n    (mem_ble_n),
  .oe_n     (mem_oe_n),
  .we_n     (mem_we_n),
  .dq_oe    (mem_dq_oe),
  .ready    (req_ready),
  .phase    (phase),
  .wait_act (wait_act)
);

// File: tb/sim_sbc_top.sv
`timescale 1ns/1ps
module sim_sbc_top;

  localparam int CW = 49;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic          req_ready;
  logic [1:0]    req_bank = '0;
  logic [23:0]   req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic [1:0]    req_be = '0;
  logic [15:0]   rsp_rdata;
  logic [CW-1:0] cfgv [4];
  logic [4*CW-1:0] cfg_banks;
  logic [23:0]   mem_addr;
  logic [15:0]   mem_dq_o, mem_dq_i = '0;
  logic          mem_dq_oe, mem_oe_n, mem_we_n, mem_wait = 1'b0;
  logic [3:0]    mem_cs_n;
  logic [1:0]    mem_ble_n;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;
  assign cfg_banks = {cfgv[3], cfgv[2], cfgv[1], cfgv[0]};

  sbc_top u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be), .rsp_rdata(rsp_rdata),
    .cfg_banks(cfg_banks), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i), .mem_cs_n(mem_cs_n),
    .mem_ble_n(mem_ble_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_wait(mem_wait)
  );

  typedef struct packed {
    logic [3:0]  cs_n;
    logic [1:0]  ble_n;
    logic        oe_n;
    logic        we_n;
    logic [23:0] addr;
    logic        dq_oe;
    logic [15:0] dq_o;
    logic        rdy;
    logic        chk_rd;
    logic [15:0] rd;
    logic        wdrv;
    logic [15:0] dqin;
  } exp_t;

  exp_t  q [$];
  string tq [$];

  function automatic exp_t idle_e();
    exp_t e = '0;
    e.cs_n = 4'hF; e.ble_n = 2'b11; e.oe_n = 1'b1; e.we_n = 1'b1;
    return e;
  endfunction

  function automatic int mx1(input logic [3:0] v);
    return (v == 4'd0) ? 1 : int'(v);
  endfunction

  function automatic logic [CW-1:0] mk(
    input logic sram, mux, nar, wen, whi, input logic [3:0] bl,
    input logic [3:0] wt, wdh, wds, wah, was,
    input logic [3:0] rt, rdh, rds, rah, ras);
    return {sram, mux, nar, wen, whi, bl, wt, wdh, wds, wah, was, rt, rdh, rds, rah, ras};
  endfunction

  task automatic push(input exp_t e, input string t);
    q.push_back(e); tq.push_back(t);
  endtask

  task automatic chk(input string t, input string nm, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", t, nm, act, exp, $time);
    end
  endtask

  // behavioural reference: per-clock pin expectation for one access
  task automatic build(input int b, input bit w, input logic [23:0] a,
                       input logic [15:0] wd, input logic [1:0] be, input int nw);
    logic [CW-1:0] c;
    int bl, as_, ah, ds, dh, tn, dlen;
    bit mux, nar, wen, whi;
    logic [15:0] pat, wv;
    exp_t base, ph, e;
    c = cfgv[b];
    bl = mx1(c[43:40]);
    if (w) begin as_ = mx1(c[23:20]); ah = int'(c[27:24]); ds = mx1(c[31:28]); dh = int'(c[35:32]); tn = int'(c[39:36]); end
    else   begin as_ = mx1(c[3:0]);   ah = int'(c[7:4]);   ds = mx1(c[11:8]);  dh = int'(c[15:12]); tn = int'(c[19:16]); end
    mux = c[47] && !c[48]; nar = c[46]; wen = c[45]; whi = c[44];
    pat = a[15:0] ^ 16'hA5C3;
    wv  = nar ? {8'h00, wd[7:0]} : wd;
    base = idle_e(); base.addr = a; base.ble_n = nar ? 2'b10 : ~be; base.wdrv = !whi;
    for (int i = 0; i < bl; i++) push(base, nar ? "R9" : "R2");
    ph = base; ph.cs_n = ~(4'b0001 << b);
    for (int i = 0; i < as_; i++) begin
      e = ph; if (mux) begin e.dq_oe = 1'b1; e.dq_o = a[15:0]; end
      push(e, mux ? "R4" : "R2");
    end
    if (mux) for (int i = 0; i < ah; i++) begin
      e = ph; e.dq_oe = 1'b1; e.dq_o = a[15:0]; push(e, "R4");
    end
    dlen = (wen && (nw + 1 > ds)) ? nw + 1 : ds;
    for (int i = 0; i < dlen; i++) begin
      e = ph;
      if (w) begin e.we_n = 1'b0; e.dq_oe = 1'b1; e.dq_o = wv; end
      else e.oe_n = 1'b0;
      e.wdrv = (i < nw) ? whi : !whi;
      e.dqin = (i == dlen - 1) ? pat : ~pat;
      push(e, (nw > 0) ? "R10" : (w ? "R3" : "R2"));
    end
    for (int i = 0; i < dh; i++) begin
      e = ph; if (w) begin e.dq_oe = 1'b1; e.dq_o = wv; end
      push(e, "R8");
    end
    e = idle_e(); e.rdy = 1'b1; e.chk_rd = !w; e.rd = nar ? {8'h00, pat[7:0]} : pat;
    push(e, w ? "R6" : "R7");
    for (int i = 0; i < ((tn > 1) ? tn : 1); i++) push(idle_e(), "R5");
  endtask

  task automatic step(output bit rdy);
    exp_t e; string t;
    @(negedge clk);
    if (q.size() > 0) begin e = q.pop_front(); t = tq.pop_front(); end
    else begin e = idle_e(); t = "R1"; end
    mem_wait = e.wdrv; mem_dq_i = e.dqin;
    #1;
    chk(t, "cs_n",  {28'h0, mem_cs_n},  {28'h0, e.cs_n});
    chk(t, "ble_n", {30'h0, mem_ble_n}, {30'h0, e.ble_n});
    chk(t, "oe_n",  {31'h0, mem_oe_n},  {31'h0, e.oe_n});
    chk(t, "we_n",  {31'h0, mem_we_n},  {31'h0, e.we_n});
    chk(t, "addr",  {8'h0, mem_addr},   {8'h0, e.addr});
    chk(t, "dq_oe", {31'h0, mem_dq_oe}, {31'h0, e.dq_oe});
    if (e.dq_oe) chk(t, "dq_o", {16'h0, mem_dq_o}, {16'h0, e.dq_o});
    chk(t, "ready", {31'h0, req_ready}, {31'h0, e.rdy});
    if (e.chk_rd) chk(t, "rdata", {16'h0, rsp_rdata}, {16'h0, e.rd});
    rdy = e.rdy;
  endtask

  task automatic run_req(input int b, input bit w, input logic [23:0] a,
                         input logic [15:0] wd, input logic [1:0] be, input int nw);
    bit r = 0; int n = 0;
    req_valid = 1'b1; req_write = w; req_bank = 2'(b);
    req_addr = a; req_wdata = wd; req_be = be;
    build(b, w, a, wd, be, nw);
    while (!r && n < 400) begin step(r); n++; end
    if (!r) begin n_bad++; $display("FAIL R6 watchdog: no ready actual=0 expected=1"); end
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    bit r;
    for (int i = 0; i < n; i++) step(r);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) cfgv[i] = '0;
    // R1: reset state of the pins
    repeat (2) begin
      @(negedge clk); #1;
      chk("R1", "rst cs_n",  {28'h0, mem_cs_n},  32'hF);
      chk("R1", "rst ble_n", {30'h0, mem_ble_n}, 32'h3);
      chk("R1", "rst strobes", {30'h0, mem_oe_n, mem_we_n}, 32'h3);
      chk("R1", "rst dq_oe", {31'h0, mem_dq_oe}, 32'h0);
      chk("R1", "rst ready", {31'h0, req_ready}, 32'h0);
    end
    rst_n = 1'b1;
    idle(2);

    // R2 R9: all-zero config, 16-bit, minimum phases
    run_req(0, 0, 24'h000123, 16'h0, 2'b11, 0);
    run_req(0, 1, 24'h0A0456, 16'hBEEF, 2'b10, 0);
    idle(3);

    // R3: write timings differ from read timings
    cfgv[1] = mk(0,0,0,0,0, 4'd2, 4'd2,4'd1,4'd2,4'd0,4'd3, 4'd0,4'd2,4'd4,4'd0,4'd1);
    idle(2);
    run_req(1, 1, 24'h1234AA, 16'hC3A5, 2'b01, 0);
    run_req(1, 0, 24'h0055F0, 16'h0, 2'b11, 0);
    idle(3);

    // R4 R9: multiplexed, 8-bit bank
    cfgv[2] = mk(0,1,1,0,0, 4'd1, 4'd1,4'd1,4'd1,4'd1,4'd2, 4'd1,4'd0,4'd2,4'd2,4'd1);
    // R4: SRAM-type bank ignores the multiplex bit
    cfgv[3] = mk(1,1,0,0,0, 4'd0, 4'd0,4'd0,4'd1,4'd3,4'd1, 4'd0,4'd0,4'd1,4'd3,4'd2);
    idle(2);
    run_req(2, 0, 24'h00ABCD, 16'h0, 2'b01, 0);
    run_req(2, 1, 24'h7F1357, 16'h9A5E, 2'b11, 0);
    run_req(3, 0, 24'h003C3C, 16'h0, 2'b11, 0);
    idle(3);

    // R10: wait active low stretches a read
    cfgv[0] = mk(0,0,0,1,0, 4'd0, 4'd0,4'd0,4'd1,4'd0,4'd0, 4'd0,4'd1,4'd2,4'd0,4'd0);
    idle(2);
    run_req(0, 0, 24'h000F0F, 16'h0, 2'b11, 4);
    idle(2);
    // R10: active-high wait on a write
    cfgv[0] = mk(0,0,0,1,1, 4'd0, 4'd1,4'd0,4'd1,4'd0,4'd0, 4'd0,4'd0,4'd2,4'd0,4'd0);
    idle(3);
    run_req(0, 1, 24'h00E0E0, 16'h5A5A, 2'b11, 3);
    idle(3);
    // R10: wait disabled, asserted level has no effect
    cfgv[0] = mk(0,0,0,0,0, 4'd0, 4'd0,4'd0,4'd0,4'd0,4'd0, 4'd0,4'd0,4'd2,4'd0,4'd0);
    idle(2);
    run_req(0, 0, 24'h000777, 16'h0, 2'b11, 3);
    idle(3);

    // R5 R6: back-to-back with and without turnaround
    cfgv[1] = mk(0,0,0,0,0, 4'd1, 4'd3,4'd0,4'd1,4'd0,4'd1, 4'd0,4'd0,4'd1,4'd0,4'd1);
    idle(2);
    run_req(1, 0, 24'h000101, 16'h0, 2'b11, 0);
    run_req(1, 1, 24'h000202, 16'h1111, 2'b11, 0);
    run_req(1, 0, 24'h000303, 16'h0, 2'b11, 0);
    idle(6);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule